// File: doc/BRIEF.md
# Interpolating Quadrature Sine/Cosine Synthesizer

This block is a direct digital frequency synthesizer. A phase accumulator of `PHASE_W` bits adds a tuning word on every clock that the output stage can move. Two amplitude paths turn the accumulated phase into a sine sample and a cosine sample. The cosine path is the sine path fed with the phase plus a quarter turn. With the default 20-bit accumulator and a 30 MHz sample clock, one tuning-word step is about 28.6 Hz.

Each path folds the phase into the first quadrant using the two top phase bits. It then splits the folded phase into a table index and a fraction. The amplitude is interpolated linearly between two neighbouring entries of a 17-entry constant table: 16 points across the quadrant plus one endpoint at full scale. The result is rounded, scaled to a signed `OUT_W`-bit amplitude of full scale `AMP = 2^(OUT_W-1)-1` (255 by default), and negated in the second half of the turn. The pipeline is two stages deep: one stage for the fold and one for the interpolation.

The output is a valid/ready stream. A sample is transferred on a rising edge where `smp_valid` and `smp_ready` are both high. While the sink holds off, the whole pipeline and the accumulator freeze, so the phase sequence stays continuous. The tuning word is a plain control input and is sampled on every edge where the pipeline advances.

Top module: `dds_quad_synth`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `smp_valid` is low. Reset clears the accumulator to phase 0, so the first valid sample is sine 0 and cosine +AMP (255).
- R2: `smp_valid` rises on the second rising edge after `rst` is released, whatever `smp_ready` is. It then stays high until the next reset.
- R3: Sample k carries the phase equal to the sum of the tuning words sampled on the first k advance edges, modulo 2^PHASE_W, with no saturation. A word of 2^(PHASE_W-1) or more turns the phase backwards.
- R4: A new tuning word is used on the next advance edge. The sample after that edge is offset from its predecessor by the new word.
- R5: The sine sample for phase p is within 2 LSB of AMP*sin(2*pi*p/2^PHASE_W).
- R6: The cosine sample for phase p is within 2 LSB of AMP*cos(2*pi*p/2^PHASE_W). The sum of the squares of the two samples lies between (AMP-3)^2 and (AMP+3)^2.
- R7: The cosine sample at phase p is bit-identical to the sine sample at phase p + 2^(PHASE_W-2).
- R8: The sine at phase p + 2^(PHASE_W-1) is the exact negation of the sine at p. At the quadrant boundaries 0, 1/4, 1/2 and 3/4 turn, the sine is exactly 0, AMP, 0, -AMP and the cosine is exactly AMP, 0, -AMP, 0.
- R9: The pipeline advances on an edge where `smp_valid` is low or `smp_ready` is high. While `smp_valid` is high and `smp_ready` is low, both samples and the accumulator hold, so no sample is dropped or repeated.
- R10: Samples are two's-complement `OUT_W`-bit values and never leave the range -AMP to +AMP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_word | input | PHASE_W | Phase increment per advance (frequency tuning word) |
| smp_ready | input | 1 | Sink accepts the current sample pair |
| smp_valid | output | 1 | Sample pair on `smp_sin`/`smp_cos` is valid |
| smp_sin | output | OUT_W | Signed sine amplitude |
| smp_cos | output | OUT_W | Signed cosine amplitude |

## Verification
The hardest cases to reach from the ports are the exact quadrant-boundary phases. Only there does the fold produce the endpoint index, use the 17th table entry, or take the mirror of a zero offset. A tuning word of exactly a quarter turn lands every sample on a boundary. A word of 1/256 turn gives pairs of samples a quarter and a half turn apart, so the bit-exact identities can be compared directly. Back-pressure is exercised with a pseudo-random ready pattern on a phase that runs backwards. This shows that stalls neither skip nor repeat a phase, and that the held outputs do not move.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Table geometry: 2^TBL_IDX_W segments across one quadrant, plus an endpoint.
  localparam int TBL_IDX_W = 4;
  localparam int TBL_W     = 16;

  typedef logic [TBL_W-1:0]   tbl_word_t;
  typedef logic [TBL_IDX_W:0] tbl_idx_t;

  // Quarter-wave samples sin(k*pi/32) scaled by 32767; entry 16 is full scale.
  function automatic tbl_word_t quarter_point(input tbl_idx_t k);
    tbl_word_t v;
    case (k)
      5'd0:  v = 16'd0;
      5'd1:  v = 16'd3212;
      5'd2:  v = 16'd6393;
      5'd3:  v = 16'd9512;
      5'd4:  v = 16'd12539;
      5'd5:  v = 16'd15446;
      5'd6:  v = 16'd18204;
      5'd7:  v = 16'd20787;
      5'd8:  v = 16'd23170;
      5'd9:  v = 16'd25329;
      5'd10: v = 16'd27245;
      5'd11: v = 16'd28898;
      5'd12: v = 16'd30273;
      5'd13: v = 16'd31356;
      5'd14: v = 16'd32137;
      5'd15: v = 16'd32609;
      default: v = 16'd32767;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic [PHASE_W-1:0] step,
  output logic [PHASE_W-1:0] phase
);

  // Wraps modulo 2^PHASE_W; holds while the pipeline is stalled.
  always_ff @(posedge clk) begin
    if (rst)      phase <= '0;
    else if (adv) phase <= phase + step;
  end

endmodule

// File: rtl/dds_quad_fold.sv
module dds_quad_fold
  import dds_pkg::*;
#(
  parameter int PHASE_W = 20
) (
  input  logic [PHASE_W-1:0]                     phase,
  output logic                                   neg,
  output tbl_idx_t                               idx,
  output logic [PHASE_W-3-TBL_IDX_W:0]           frac
);

  localparam int R_W    = PHASE_W - 2;
  localparam int FRAC_W = R_W - TBL_IDX_W;

  logic [1:0]     quad;
  logic [R_W-1:0] off;
  logic [R_W:0]   folded;

  assign quad = phase[PHASE_W-1 -: 2];
  assign off  = phase[R_W-1:0];

  // Exact mirror in quadrants 1 and 3: a full quadrant minus the offset,
  // so a zero offset reaches the endpoint entry.
  always_comb begin
    if (quad[0]) folded = {1'b1, {R_W{1'b0}}} - {1'b0, off};
    else         folded = {1'b0, off};
  end

  assign neg  = quad[1];
  assign idx  = folded[R_W:FRAC_W];
  assign frac = folded[FRAC_W-1:0];

endmodule

// File: rtl/dds_interp.sv
module dds_interp
  import dds_pkg::*;
#(
  parameter int OUT_W  = 9,
  parameter int FRAC_W = 14
) (
  input  logic                     neg,
  input  tbl_idx_t                 idx,
  input  logic [FRAC_W-1:0]        frac,
  output logic signed [OUT_W-1:0]  amp
);

  localparam int AMP    = (1 << (OUT_W - 1)) - 1;
  localparam int PROD_W = FRAC_W + TBL_W;
  localparam int SC_W   = TBL_W + OUT_W;
  localparam int MAG_W  = OUT_W - 1;

  localparam logic [PROD_W-1:0] P_HALF = PROD_W'(1) << (FRAC_W - 1);
  localparam logic [SC_W-1:0]   S_HALF = SC_W'(1) << (TBL_W - 2);
  localparam logic [SC_W-1:0]   S_AMP  = SC_W'(AMP);

  tbl_idx_t          idx_nx;
  tbl_word_t         lo, hi, dlt, y;
  logic [PROD_W-1:0] prod;
  logic [SC_W-1:0]   sc;
  logic [MAG_W-1:0]  mag;

  // The endpoint index occurs only with a zero fraction; clamp its neighbour.
  assign idx_nx = idx[TBL_IDX_W] ? idx : idx + {{TBL_IDX_W{1'b0}}, 1'b1};

  always_comb begin
    lo   = quarter_point(idx);
    hi   = quarter_point(idx_nx);
    dlt  = hi - lo;
    prod = {{TBL_W{1'b0}}, frac} * {{FRAC_W{1'b0}}, dlt} + P_HALF;
    y    = lo + TBL_W'(prod >> FRAC_W);
    sc   = SC_W'(y) * S_AMP + S_HALF;
    mag  = MAG_W'(sc >> (TBL_W - 1));
    amp  = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

endmodule

// File: rtl/dds_quad_synth.sv
module dds_quad_synth
  import dds_pkg::*;
#(
  parameter int PHASE_W = 20,
  parameter int OUT_W   = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PHASE_W-1:0]       tune_word,
  input  logic                     smp_ready,
  output logic                     smp_valid,
  output logic signed [OUT_W-1:0]  smp_sin,
  output logic signed [OUT_W-1:0]  smp_cos
);

  localparam int FRAC_W = PHASE_W - 2 - TBL_IDX_W;
  localparam int N_CH   = 2;
  localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(1) << (PHASE_W - 2);

  logic               adv;
  logic               fold_vld;
  logic [PHASE_W-1:0] acc;

  // Whole pipeline moves together; a stalled sink freezes every stage.
  assign adv = !smp_valid || smp_ready;

  dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .adv   (adv),
    .step  (tune_word),
    .phase (acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fold_vld  <= 1'b0;
      smp_valid <= 1'b0;
    end else if (adv) begin
      fold_vld  <= 1'b1;
      smp_valid <= fold_vld;
    end
  end

  // Channel 0: sine at the accumulated phase; channel 1: a quarter turn ahead.
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [PHASE_W-1:0]        ch_phase;
    logic                      f_neg;
    tbl_idx_t                  f_idx;
    logic [FRAC_W-1:0]         f_frac;
    logic                      s1_neg;
    tbl_idx_t                  s1_idx;
    logic [FRAC_W-1:0]         s1_frac;
    logic signed [OUT_W-1:0]   amp_d;
    logic signed [OUT_W-1:0]   amp_q;

    if (c == 0) begin : g_sin
      assign ch_phase = acc;
    end else begin : g_cos
      assign ch_phase = acc + QUARTER;
    end

    dds_quad_fold #(.PHASE_W(PHASE_W)) u_fold (
      .phase (ch_phase),
      .neg   (f_neg),
      .idx   (f_idx),
      .frac  (f_frac)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_neg  <= 1'b0;
        s1_idx  <= '0;
        s1_frac <= '0;
      end else if (adv) begin
        s1_neg  <= f_neg;
        s1_idx  <= f_idx;
        s1_frac <= f_frac;
      end
    end

    dds_interp #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_interp (
      .neg  (s1_neg),
      .idx  (s1_idx),
      .frac (s1_frac),
      .amp  (amp_d)
    );

    always_ff @(posedge clk) begin
      if (rst)      amp_q <= '0;
      else if (adv) amp_q <= amp_d;
    end
  end

  assign smp_sin = g_ch[0].amp_q;
  assign smp_cos = g_ch[1].amp_q;

endmodule

// File: rtl/dds_quad_synth_chk.sv
module dds_quad_synth_chk #(
  parameter int OUT_W = 9
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    smp_ready,
  input logic                    smp_valid,
  input logic signed [OUT_W-1:0] smp_sin,
  input logic signed [OUT_W-1:0] smp_cos
);

  localparam int AMP    = (1 << (OUT_W - 1)) - 1;
  localparam int RAD_LO = (AMP - 3) * (AMP - 3);
  localparam int RAD_HI = (AMP + 3) * (AMP + 3);

  int rad;
  always_comb rad = int'(smp_sin) * int'(smp_sin) + int'(smp_cos) * int'(smp_cos);

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !smp_valid);

  a_r1_first_pair: assert property (@(posedge clk) disable iff (rst)
    $rose(smp_valid) |-> (smp_sin == 0) && (int'(smp_cos) == AMP));

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    (!rst && $past(rst)) |=> !smp_valid ##1 smp_valid);

  a_r2_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> smp_valid);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !smp_ready) |=> smp_valid && $stable(smp_sin) && $stable(smp_cos));

  a_r10_range: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> (int'(smp_sin) >= -AMP) && (int'(smp_cos) >= -AMP));

  a_r6_radius: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> (rad >= RAD_LO) && (rad <= RAD_HI));

endmodule

bind dds_quad_synth dds_quad_synth_chk #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_ready (smp_ready),
  .smp_valid (smp_valid),
  .smp_sin   (smp_sin),
  .smp_cos   (smp_cos)
);

// File: tb/sim_dds_quad_synth.sv
`timescale 1ns/1ps
module sim_dds_quad_synth;

  localparam int  PW   = 20;
  localparam int  OW   = 9;
  localparam int  AMP  = 255;
  localparam int  MAXS = 4300;
  localparam real TWO_PI = 6.283185307179586;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [PW-1:0]        tune_word = '0;
  logic                 smp_ready = 1'b1;
  logic                 smp_valid;
  logic signed [OW-1:0] smp_sin, smp_cos;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [PW-1:0] ph [MAXS];
  int            s_arr [MAXS];
  int            c_arr [MAXS];
  logic [15:0]   lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  dds_quad_synth #(.PHASE_W(PW), .OUT_W(OW)) u0 (
    .clk(clk), .rst(rst), .tune_word(tune_word), .smp_ready(smp_ready),
    .smp_valid(smp_valid), .smp_sin(smp_sin), .smp_cos(smp_cos)
  );

  task automatic chk(input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic real ref_amp(input logic [PW-1:0] p, input bit cosine);
    real a = TWO_PI * $itor(p) / $itor(1 << PW);
    return cosine ? AMP * $cos(a) : AMP * $sin(a);
  endfunction

  // One run: reset, then stream nsmp samples; word fa for the first sw advances, fb after.
  task automatic run_case(input logic [PW-1:0] fa, input int sw, input logic [PW-1:0] fb,
                          input int nsmp, input bit stall, input string rq);
    int adv_n = 0;
    int n = 0;
    int cyc = 0;
    bit hold = 0;
    int hs = 0;
    int hc = 0;
    real es, ec;
    rst = 1'b1; smp_ready = 1'b1; tune_word = fa;
    repeat (3) @(negedge clk);
    chk(smp_valid == 1'b0, $sformatf("R1 valid in reset: actual=%0b expected=0", smp_valid));
    ph[0] = '0;
    rst = 1'b0;
    while (n < nsmp) begin
      tune_word = (adv_n < sw) ? fa : fb;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      smp_ready = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
      if (cyc < 2)
        chk(smp_valid == 1'b0, $sformatf("R2 early valid cyc%0d: actual=%0b expected=0", cyc, smp_valid));
      else
        chk(smp_valid == 1'b1, $sformatf("R2 valid cyc%0d: actual=%0b expected=1", cyc, smp_valid));
      if (hold)
        chk(int'(smp_sin) == hs && int'(smp_cos) == hc,
            $sformatf("R9 stall hold: actual=%0d/%0d expected=%0d/%0d", smp_sin, smp_cos, hs, hc));
      hold = smp_valid && !smp_ready;
      hs = int'(smp_sin); hc = int'(smp_cos);
      if (smp_valid && smp_ready) begin
        es = ref_amp(ph[n], 1'b0);
        ec = ref_amp(ph[n], 1'b1);
        chk(($itor(smp_sin) - es) <= 2.0 && (es - $itor(smp_sin)) <= 2.0,
            $sformatf("R5 %s sine k=%0d: actual=%0d expected=%0.2f", rq, n, smp_sin, es));
        chk(($itor(smp_cos) - ec) <= 2.0 && (ec - $itor(smp_cos)) <= 2.0,
            $sformatf("R6 %s cosine k=%0d: actual=%0d expected=%0.2f", rq, n, smp_cos, ec));
        chk(int'(smp_sin) >= -AMP && int'(smp_sin) <= AMP && int'(smp_cos) >= -AMP && int'(smp_cos) <= AMP,
            $sformatf("R10 range: actual=%0d/%0d expected=|x|<=%0d", smp_sin, smp_cos, AMP));
        if (n == 0)
          chk(smp_sin == 0 && int'(smp_cos) == AMP,
              $sformatf("R1 first pair: actual=%0d/%0d expected=0/%0d", smp_sin, smp_cos, AMP));
        s_arr[n] = int'(smp_sin);
        c_arr[n] = int'(smp_cos);
        n++;
      end
      if (!smp_valid || smp_ready) begin
        ph[adv_n + 1] = ph[adv_n] + tune_word;
        adv_n++;
      end
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    int qs [4] = '{0, AMP, 0, -AMP};
    int qc [4] = '{AMP, 0, -AMP, 0};

    // Quadrant boundaries, exact values (R8) and wrap (R3).
    run_case(20'h40000, 0, 20'h40000, 12, 1'b0, "R3 quarter step");
    for (int k = 0; k < 12; k++)
      chk(s_arr[k] == qs[k % 4] && c_arr[k] == qc[k % 4],
          $sformatf("R8 boundary k=%0d: actual=%0d/%0d expected=%0d/%0d", k, s_arr[k], c_arr[k], qs[k%4], qc[k%4]));

    // Bit-exact quarter and half turn identities (R7, R8).
    run_case(20'd4096, 0, 20'd4096, 400, 1'b0, "R3 1/256 turn");
    for (int k = 0; k + 128 < 400; k++) begin
      chk(s_arr[k + 64] == c_arr[k],
          $sformatf("R7 k=%0d: actual=%0d expected=%0d", k, c_arr[k], s_arr[k + 64]));
      chk(s_arr[k + 128] == -s_arr[k],
          $sformatf("R8 odd k=%0d: actual=%0d expected=%0d", k, s_arr[k + 128], -s_arr[k]));
    end

    // Near-exhaustive sweep of a full turn.
    run_case(20'd257, 0, 20'd257, 4100, 1'b0, "R3 sweep");

    // Backward rotation under random back-pressure (R9, R3).
    run_case(20'hFEDCB, 0, 20'hFEDCB, 900, 1'b1, "R9 stall");

    // Tuning word change mid stream (R4), with stalls.
    run_case(20'd1000, 40, 20'd77777, 300, 1'b1, "R4 retune");

    // Zero word: constant output.
    run_case(20'd0, 0, 20'd0, 20, 1'b0, "R3 zero step");
    for (int k = 0; k < 20; k++)
      chk(s_arr[k] == 0 && c_arr[k] == AMP,
          $sformatf("R3 zero step k=%0d: actual=%0d/%0d expected=0/%0d", k, s_arr[k], c_arr[k], AMP));

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule